// File: doc/BRIEF.md
# Programmable PAL Vertical Sync and Field Flag Generator

This block produces the vertical sync level and the field flag for an interlaced 625-line digital video output. It counts lines from a per-line strobe and splits each frame into an odd field (frame lines 0 to 312) and an even field (frame lines 313 to 624). A second strobe marks the middle of each line. The vertical sync level drives an output pin and also supplies the V bit used when timing reference codes are built downstream. The field flag supplies the F bit.

Software sets the timing through a small byte-wide write port. The rising and falling edges of vsync are each placed by a 5-bit line count. The count is added to a fixed reference line, or taken away from it. Each field can add one more line of its own, and each edge can move to mid-line separately in each field. The point where the field flag takes its new value has its own position and its own per-field one-line delays. Writes go into pending copies. The working copies take them at the next field boundary, so a field never sees a half-applied setting.

Top module: `pal_vs_timing_gen`

## Requirements
- R1: `lineNum` counts 0 to 624 and moves on by one for each `lineStrobe`, wrapping from 624 to 0. `oddField` is 1 for lines 0 to 312 and 0 for lines 313 to 624, and it changes only on entry to line 0 or line 313. A field line number is the frame line (odd field) or the frame line minus 313 (even field).
- R2: After reset, `vsOut`, `vBit`, `fBit` and `oddField` are 0 and `lineNum` is 624. The default registers are begin 0x11, end 0x14, flag 0x00 and half 0x0C. With these defaults, in every field vsync rises at the mid-line strobe of field line 49 and falls at the start of field line 52, giving 2.5 lines high.
- R3: Address 0 (begin edge) and address 1 (end edge) share one layout: bit 7 is the odd-field extra delay, bit 6 is the even-field extra delay, bit 5 is advance, and bits 4:0 are the count N. The edge line is 32+N when advance is 0 and 32−N when advance is 1, plus 1 when the delay bit of the current field is set.
- R4: The odd-field and even-field delay bits are independent. A bit changes only its own field's edge.
- R5: Address 3 bits select mid-line edges: bit 3 for the begin edge in odd fields, bit 2 for the begin edge in even fields, bit 1 for the end edge in odd fields, bit 0 for the end edge in even fields. A selected edge takes effect at the `halfStrobe` of its line. An unselected edge takes effect at the `lineStrobe` that enters its line. A `halfStrobe` in the same cycle as a `lineStrobe` is ignored.
- R6: `vsOut` and `vBit` are equal in every cycle.
- R7: Address 2 holds the flag position P in bits 4:0, the odd-field delay in bit 7 and the even-field delay in bit 6. On entry to field line P (plus 1 if that field's delay bit is set), `fBit` takes 0 in an odd field and 1 in an even field.
- R8: A register write takes effect from the next field boundary. The field in progress keeps its old timing.
- R9: When the begin and end edges fall on the same strobe, the end edge wins and vsync stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStrobe | input | 1 | One-cycle pulse at the start of each line |
| halfStrobe | input | 1 | One-cycle pulse at mid-line |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 2 | Register select: 0 begin, 1 end, 2 flag, 3 half |
| regWrData | input | 8 | Register write data |
| vsOut | output | 1 | Vertical sync pin level |
| vBit | output | 1 | V bit for the timing reference codes |
| fBit | output | 1 | F bit (0 odd, 1 even) |
| oddField | output | 1 | Current field is the odd field |
| lineNum | output | 10 | Frame line counter |

## Verification
The bench runs whole fields and records the half-line index of each vsync edge and the field line of each flag change. It then compares these against positions worked out by hand. Advance mode with an odd-only delay catches a design that ignores the sign or applies a delay bit to both fields; such a design moves the even-field edge. A write made in the middle of a field catches a design that applies a setting at once, because the current field's end line would move. Setting both edges to the same line catches a design that gives the set priority, which would leave vsync stuck high for the rest of the field.

// File: rtl/pal_vs_pkg.sv
package pal_vs_pkg;

  localparam int POS_W = 5;

  // Edge control byte: odd delay, even delay, advance, line count.
  typedef struct packed {
    logic             dlyOdd;
    logic             dlyEven;
    logic             advance;
    logic [POS_W-1:0] pos;
  } edgeCtl_t;

  // Field flag control: bit 5 of the byte is not stored.
  typedef struct packed {
    logic             dlyOdd;
    logic             dlyEven;
    logic [POS_W-1:0] pos;
  } togCtl_t;

  typedef struct packed {
    logic begOdd;
    logic begEven;
    logic endOdd;
    logic endEven;
  } halfCtl_t;

  typedef struct packed {
    edgeCtl_t beginCtl;
    edgeCtl_t endCtl;
    togCtl_t  togCtl;
    halfCtl_t halfCtl;
  } timingCfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic commit;
    logic vsSet;
    logic vsClr;
    logic fLoad;
    logic fVal;
  } ctlStrobes_t;

  localparam edgeCtl_t BEGIN_RST = edgeCtl_t'(8'h11);
  localparam edgeCtl_t END_RST   = edgeCtl_t'(8'h14);
  localparam togCtl_t  TOG_RST   = togCtl_t'(7'h00);
  localparam halfCtl_t HALF_RST  = halfCtl_t'(4'hC);

  localparam logic [1:0] ADDR_BEGIN = 2'd0;
  localparam logic [1:0] ADDR_END   = 2'd1;
  localparam logic [1:0] ADDR_TOG   = 2'd2;
  localparam logic [1:0] ADDR_HALF  = 2'd3;

endpackage

// File: rtl/pal_vs_edge_calc.sv
module pal_vs_edge_calc
  import pal_vs_pkg::*;
#(
  parameter int LINE_W   = 10,
  parameter int REF_LINE = 32
) (
  input  edgeCtl_t          ctl,
  input  logic              halfOdd,
  input  logic              halfEven,
  input  logic              odd,
  output logic [LINE_W-1:0] lineNo,
  output logic              atHalf
);

  localparam logic [LINE_W-1:0] REF = LINE_W'(REF_LINE);

  logic [LINE_W-1:0] posExt;
  logic [LINE_W-1:0] baseLine;
  logic              fieldDly;

  assign posExt   = LINE_W'(ctl.pos);
  assign fieldDly = odd ? ctl.dlyOdd : ctl.dlyEven;

  always_comb begin
    baseLine = ctl.advance ? (REF - posExt) : (REF + posExt);
    lineNo   = baseLine + LINE_W'(fieldDly);
  end

  assign atHalf = odd ? halfOdd : halfEven;

endmodule

// File: rtl/pal_vs_control.sv
module pal_vs_control
  import pal_vs_pkg::*;
#(
  parameter int LINES_PER_FRAME = 625,
  parameter int ODD_LINES       = 313,
  parameter int REF_LINE        = 32,
  parameter int LINE_W          = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStrobe,
  input  logic              halfStrobe,
  input  timingCfg_t        pendCfg,
  input  timingCfg_t        actCfg,
  output ctlStrobes_t       strobes,
  output logic [LINE_W-1:0] lineCnt,
  output logic              oddField
);

  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_FRAME - 1);
  localparam logic [LINE_W-1:0] EVEN_START = LINE_W'(ODD_LINES);
  localparam int NUM_EDGES = 2;

  logic [LINE_W-1:0] nextLine;
  logic [LINE_W-1:0] nextFieldLine;
  logic [LINE_W-1:0] curFieldLine;
  logic [LINE_W-1:0] togLine;
  logic              nextOdd;
  logic              boundary;
  timingCfg_t        cfgLine;

  assign nextLine      = (lineCnt == LAST_LINE) ? '0 : lineCnt + 1'b1;
  assign nextOdd       = nextLine < EVEN_START;
  assign boundary      = lineStrobe && ((nextLine == '0) || (nextLine == EVEN_START));
  assign nextFieldLine = nextOdd ? nextLine : nextLine - EVEN_START;
  assign curFieldLine  = oddField ? lineCnt : lineCnt - EVEN_START;

  // At a boundary the entering field already uses the pending settings.
  assign cfgLine = boundary ? pendCfg : actCfg;

  logic [NUM_EDGES-1:0] lineHit;
  logic [NUM_EDGES-1:0] halfHit;

  for (genvar g = 0; g < NUM_EDGES; g++) begin : gEdge
    edgeCtl_t          lnCtl;
    edgeCtl_t          hfCtl;
    logic              lnHalfOdd, lnHalfEven, hfHalfOdd, hfHalfEven;
    logic [LINE_W-1:0] lnLine, hfLine;
    logic              lnAtHalf, hfAtHalf;

    assign lnCtl      = (g == 0) ? cfgLine.beginCtl : cfgLine.endCtl;
    assign hfCtl      = (g == 0) ? actCfg.beginCtl : actCfg.endCtl;
    assign lnHalfOdd  = (g == 0) ? cfgLine.halfCtl.begOdd  : cfgLine.halfCtl.endOdd;
    assign lnHalfEven = (g == 0) ? cfgLine.halfCtl.begEven : cfgLine.halfCtl.endEven;
    assign hfHalfOdd  = (g == 0) ? actCfg.halfCtl.begOdd  : actCfg.halfCtl.endOdd;
    assign hfHalfEven = (g == 0) ? actCfg.halfCtl.begEven : actCfg.halfCtl.endEven;

    // Line-start path: evaluated for the line being entered.
    pal_vs_edge_calc #(.LINE_W(LINE_W), .REF_LINE(REF_LINE)) u_lnCalc (
      .ctl      (lnCtl),
      .halfOdd  (lnHalfOdd),
      .halfEven (lnHalfEven),
      .odd      (nextOdd),
      .lineNo   (lnLine),
      .atHalf   (lnAtHalf)
    );

    // Mid-line path: evaluated for the line in progress.
    pal_vs_edge_calc #(.LINE_W(LINE_W), .REF_LINE(REF_LINE)) u_hfCalc (
      .ctl      (hfCtl),
      .halfOdd  (hfHalfOdd),
      .halfEven (hfHalfEven),
      .odd      (oddField),
      .lineNo   (hfLine),
      .atHalf   (hfAtHalf)
    );

    assign lineHit[g] = lineStrobe && (nextFieldLine == lnLine) && !lnAtHalf;
    assign halfHit[g] = halfStrobe && !lineStrobe && (curFieldLine == hfLine) && hfAtHalf;
  end

  always_comb begin
    togLine = LINE_W'(cfgLine.togCtl.pos)
            + LINE_W'(nextOdd ? cfgLine.togCtl.dlyOdd : cfgLine.togCtl.dlyEven);
    strobes.commit = boundary;
    strobes.vsSet  = lineHit[0] | halfHit[0];
    strobes.vsClr  = lineHit[1] | halfHit[1];
    strobes.fLoad  = lineStrobe && (nextFieldLine == togLine);
    strobes.fVal   = !nextOdd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt  <= LAST_LINE;
      oddField <= 1'b0;
    end else if (lineStrobe) begin
      lineCnt <= nextLine;
      if (boundary) oddField <= nextOdd;
    end
  end

endmodule

// File: rtl/pal_vs_datapath.sv
module pal_vs_datapath
  import pal_vs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWrData,
  input  ctlStrobes_t strobes,
  output timingCfg_t  pendCfg,
  output timingCfg_t  actCfg,
  output logic        vsPin,
  output logic        vCode,
  output logic        fFlag
);

  localparam timingCfg_t CFG_RST = '{
    beginCtl: BEGIN_RST,
    endCtl:   END_RST,
    togCtl:   TOG_RST,
    halfCtl:  HALF_RST
  };

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCfg <= CFG_RST;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_BEGIN: pendCfg.beginCtl <= edgeCtl_t'(regWrData);
        ADDR_END:   pendCfg.endCtl   <= edgeCtl_t'(regWrData);
        ADDR_TOG:   pendCfg.togCtl   <= togCtl_t'({regWrData[7:6], regWrData[4:0]});
        default:    pendCfg.halfCtl  <= halfCtl_t'(regWrData[3:0]);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               actCfg <= CFG_RST;
    else if (strobes.commit) actCfg <= pendCfg;
  end

  // The clear takes priority in both copies of the sync level.
  always_ff @(posedge clk) begin
    if (!rstN)              vsPin <= 1'b0;
    else if (strobes.vsClr) vsPin <= 1'b0;
    else if (strobes.vsSet) vsPin <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              vCode <= 1'b0;
    else if (strobes.vsClr) vCode <= 1'b0;
    else if (strobes.vsSet) vCode <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              fFlag <= 1'b0;
    else if (strobes.fLoad) fFlag <= strobes.fVal;
  end

endmodule

// File: rtl/pal_vs_timing_gen.sv
module pal_vs_timing_gen
  import pal_vs_pkg::*;
#(
  parameter int LINES_PER_FRAME = 625,
  parameter int ODD_LINES       = 313,
  parameter int REF_LINE        = 32,
  localparam int LINE_W         = $clog2(LINES_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStrobe,
  input  logic              halfStrobe,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic              vsOut,
  output logic              vBit,
  output logic              fBit,
  output logic              oddField,
  output logic [LINE_W-1:0] lineNum
);

  ctlStrobes_t strobes;
  timingCfg_t  pendCfg;
  timingCfg_t  actCfg;

  pal_vs_control #(
    .LINES_PER_FRAME (LINES_PER_FRAME),
    .ODD_LINES       (ODD_LINES),
    .REF_LINE        (REF_LINE),
    .LINE_W          (LINE_W)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .lineStrobe (lineStrobe),
    .halfStrobe (halfStrobe),
    .pendCfg    (pendCfg),
    .actCfg     (actCfg),
    .strobes    (strobes),
    .lineCnt    (lineNum),
    .oddField   (oddField)
  );

  pal_vs_datapath u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobes   (strobes),
    .pendCfg   (pendCfg),
    .actCfg    (actCfg),
    .vsPin     (vsOut),
    .vCode     (vBit),
    .fFlag     (fBit)
  );

endmodule

// File: rtl/pal_vs_timing_gen_chk.sv
module pal_vs_timing_gen_chk #(
  parameter int LINES_PER_FRAME = 625,
  parameter int ODD_LINES       = 313,
  parameter int LINE_W          = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineStrobe,
  input logic              halfStrobe,
  input logic              vsOut,
  input logic              vBit,
  input logic              fBit,
  input logic              oddField,
  input logic [LINE_W-1:0] lineNum
);

  localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(LINES_PER_FRAME - 1);
  localparam logic [LINE_W-1:0] EVEN_START = LINE_W'(ODD_LINES);

  a_r1_line_bound: assert property (@(posedge clk) disable iff (!rstN)
    lineNum <= LAST_LINE);

  a_r1_line_advance: assert property (@(posedge clk) disable iff (!rstN)
    lineStrobe |=> lineNum == (($past(lineNum) == LAST_LINE) ? '0 : $past(lineNum) + 1'b1));

  a_r1_line_hold: assert property (@(posedge clk) disable iff (!rstN)
    !lineStrobe |=> $stable(lineNum));

  a_r1_field_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(oddField) |-> (lineNum == '0 || lineNum == EVEN_START));

  a_r5_vs_moves_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vsOut) |-> $past(lineStrobe || halfStrobe));

  a_r6_pin_matches_code: assert property (@(posedge clk) disable iff (!rstN)
    vsOut == vBit);

  a_r7_flag_on_line_start: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fBit) |-> $past(lineStrobe));

  a_r7_flag_value: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fBit) |-> (fBit == !oddField));

endmodule

bind pal_vs_timing_gen pal_vs_timing_gen_chk #(
  .LINES_PER_FRAME (LINES_PER_FRAME),
  .ODD_LINES       (ODD_LINES),
  .LINE_W          (LINE_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lineStrobe (lineStrobe),
  .halfStrobe (halfStrobe),
  .vsOut      (vsOut),
  .vBit       (vBit),
  .fBit       (fBit),
  .oddField   (oddField),
  .lineNum    (lineNum)
);

// File: tb/pal_vs_timing_gen_tb.sv
module pal_vs_timing_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStrobe = 1'b0;
  logic       halfStrobe = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic       vsOut, vBit, fBit, oddField;
  logic [9:0] lineNum;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  pal_vs_timing_gen u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .lineStrobe (lineStrobe),
    .halfStrobe (halfStrobe),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .vsOut      (vsOut),
    .vBit       (vBit),
    .fBit       (fBit),
    .oddField   (oddField),
    .lineNum    (lineNum)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseLine();
    @(negedge clk) lineStrobe = 1'b1;
    @(negedge clk) lineStrobe = 1'b0;
  endtask

  task automatic pulseHalf();
    @(negedge clk) halfStrobe = 1'b1;
    @(negedge clk) halfStrobe = 1'b0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Runs one whole field. Edge positions are half-line indices
  // (2*fieldLine, +1 at mid-line); flag change is a field line; -1 = none.
  task automatic runField(input bit isOdd, input bit doWr, input int wrLine,
                          input logic [1:0] wa, input logic [7:0] wd,
                          output int rise, output int fall, output int fChg);
    int n;
    int mis;
    logic prevVs, prevF;
    n = isOdd ? 313 : 312;
    rise = -1; fall = -1; fChg = -1; mis = 0;
    prevVs = vsOut; prevF = fBit;
    for (int k = 0; k < n; k++) begin
      pulseLine();
      if (vsOut && !prevVs && rise < 0) rise = 2 * k;
      if (!vsOut && prevVs && fall < 0) fall = 2 * k;
      if (fBit != prevF && fChg < 0) fChg = k;
      if (vsOut != vBit) mis++;
      prevVs = vsOut; prevF = fBit;
      pulseHalf();
      if (vsOut && !prevVs && rise < 0) rise = 2 * k + 1;
      if (!vsOut && prevVs && fall < 0) fall = 2 * k + 1;
      if (vsOut != vBit) mis++;
      prevVs = vsOut;
      if (doWr && k == wrLine) writeReg(wa, wd);
    end
    check("R1 field end line", int'(lineNum), isOdd ? 312 : 624);
    check("R1 field indicator", int'(oddField), isOdd ? 1 : 0);
    check("R6 pin vs code mismatches", mis, 0);
  endtask

  task automatic testReset();
    check("R2 reset vsOut", int'(vsOut), 0);
    check("R2 reset vBit", int'(vBit), 0);
    check("R2 reset fBit", int'(fBit), 0);
    check("R2 reset oddField", int'(oddField), 0);
    check("R2 reset lineNum", int'(lineNum), 624);
  endtask

  task automatic testDefaults();
    int r, f, t;
    runField(1'b1, 1'b0, 0, 2'd0, 8'd0, r, f, t);
    check("R2 odd rise", r, 99);
    check("R2 odd fall", f, 104);
    check("R7 odd flag unchanged", t, -1);
    check("R7 flag after odd", int'(fBit), 0);
    runField(1'b0, 1'b0, 0, 2'd0, 8'd0, r, f, t);
    check("R2 even rise", r, 99);
    check("R2 even fall", f, 104);
    check("R7 even flag line", t, 0);
    check("R7 flag after even", int'(fBit), 1);
  endtask

  // R8: end count 25 written at odd field line 10
  task automatic testDeferredWrite();
    int r, f, t;
    runField(1'b1, 1'b1, 10, 2'd1, 8'h19, r, f, t);
    check("R8 odd keeps old end", f, 104);
    check("R8 odd rise", r, 99);
    runField(1'b0, 1'b0, 0, 2'd0, 8'd0, r, f, t);
    check("R8 even uses new end", f, 114);
    check("R8 even rise", r, 99);
  endtask

  // R3/R4: advance begin by 10 (line 22, mid-line), end advance 5 + odd delay
  task automatic testAdvanceDelay();
    int r, f, t;
    writeReg(2'd0, 8'h2A);
    writeReg(2'd1, 8'hA5);
    runField(1'b1, 1'b0, 0, 2'd0, 8'd0, r, f, t);
    check("R3 odd advanced rise", r, 45);
    check("R4 odd delayed fall", f, 56);
    runField(1'b0, 1'b0, 0, 2'd0, 8'd0, r, f, t);
    check("R3 even advanced rise", r, 45);
    check("R4 even undelayed fall", f, 54);
  endtask

  // R5/R4: half on begin-odd and end-odd only, begin even delay
  task automatic testHalfLine();
    int r, f, t;
    writeReg(2'd0, 8'h6A);
    writeReg(2'd1, 8'h05);
    writeReg(2'd3, 8'h0A);
    runField(1'b1, 1'b0, 0, 2'd0, 8'd0, r, f, t);
    check("R5 odd mid-line rise", r, 45);
    check("R5 odd mid-line fall", f, 75);
    runField(1'b0, 1'b0, 0, 2'd0, 8'd0, r, f, t);
    check("R4 even delayed line-start rise", r, 46);
    check("R5 even line-start fall", f, 74);
  endtask

  // R7: flag position 2 with odd delay
  task automatic testFlagToggle();
    int r, f, t;
    writeReg(2'd2, 8'h82);
    runField(1'b1, 1'b0, 0, 2'd0, 8'd0, r, f, t);
    check("R7 odd delayed flag line", t, 3);
    check("R7 flag value odd", int'(fBit), 0);
    runField(1'b0, 1'b0, 0, 2'd0, 8'd0, r, f, t);
    check("R7 even flag line", t, 2);
    check("R7 flag value even", int'(fBit), 1);
  endtask

  // R9: both edges at the start of line 52
  task automatic testCoincide();
    int r, f, t;
    writeReg(2'd0, 8'h14);
    writeReg(2'd1, 8'h14);
    writeReg(2'd3, 8'h00);
    runField(1'b1, 1'b0, 0, 2'd0, 8'd0, r, f, t);
    check("R9 no rise on coincidence", r, -1);
    check("R9 no fall on coincidence", f, -1);
    check("R9 vs low at end", int'(vsOut), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDefaults();
    testDeferredWrite();
    testAdvanceDelay();
    testHalfLine();
    testFlagToggle();
    testCoincide();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule